// File: doc/BRIEF.md
# Quadrature Position Counter with Index

This block turns two encoder phase signals and an index signal into a wrapping position count, a direction flag and a signed revolution (index) count. The phase and index inputs are assumed to be already synchronised and deglitched. Each clock samples the inputs once. Every output is registered and reflects the sample taken at the previous rising edge.

Two front-end modes are available. In quadrature mode a four-state Gray machine (`PH_00`, `PH_10`, `PH_11`, `PH_01`) holds the last phase pair. Each sample moves it along one of four named transitions: A-edge, B-edge, phase error, or no change. In step mode phase B acts as a count clock and phase A gives the direction level.

A second state machine handles position recalibration on the index pulse. Its states are `ARM_IDLE`, `ARM_ONCE`, `ARM_CONT_WAIT` and `ARM_CONT_PEND`. It supports a one-shot clear on the next accepted index, and a continuous mode that clears the position at the forward count that coincides with, or first follows, each accepted index.

Single-cycle strobes report:
- counted edges,
- phase errors,
- direction changes,
- wraps,
- accepted index pulses,
- compare matches against three position values and three index values.

Top module: `qpc_top`

## Requirements
- R1: While reset is asserted, and directly after it, position and index count are 0, `dir` is 1 (forward) and every strobe is 0.
- R2: Quadrature, 4X mode (`cfg_x4`=1): every single-phase change counts once. The forward direction is the sequence (A,B) 00→10→11→01→00 and the reverse sequence counts down. The position and `ev_count` show the result one clock after the sample.
- R3: Quadrature, 2X mode (`cfg_x4`=0): only phase A changes count. Phase B changes move the phase state but leave the position unchanged.
- R4: In quadrature mode, a sample in which both phases changed raises `ev_phase_err`, leaves the position unchanged and raises no `ev_count`.
- R5: Step mode (`cfg_step_mode`=1): a rising edge of phase B counts once, forward when phase A is 1 and backward when it is 0. No phase error is ever raised in this mode.
- R6: With `cfg_dir_inv`=1 every counted edge takes the opposite direction, for both the count and the `dir` flag. `dir` holds the direction of the last counted edge (1 = forward). `ev_dir_chg` fires on a counted edge whose direction differs from `dir`.
- R7: A forward count from a position at or above `cfg_max_pos` gives 0. A backward count from 0 gives `cfg_max_pos`. Both cases raise `ev_wrap`.
- R8: The active index level is `idx_in` XOR `cfg_idx_inv`. The gate bits are `cfg_idx_gate[0]` for (A,B)=00, [1] for 01, [2] for 11 and [3] for 10. An index pulse is accepted on the rising edge of (active index AND the gate bit of the current phase state). Acceptance raises `ev_index` and moves the index count by +1 when `dir`=1 and by −1 when `dir`=0.
- R9: `cmd_rst_pos` clears the position on the next clock, with priority over counting. `cmd_rst_idx` clears the index count on the next clock, with priority over index steps.
- R10: A pulse on `cmd_rst_pos_on_idx` arms a one-shot clear. The next accepted index sets the position to 0, and the block then disarms.
- R11: While `cfg_cont_rst`=1, each accepted index clears the position at the forward count in the same sample, or else at the first forward count after it.
- R12: `ev_pos_match[i]` fires in the cycle in which the position is written (by a count or a clear) with a value equal to `cfg_pos_cmp[i]`. `ev_idx_match[i]` fires likewise when the index count is written with a value equal to `cfg_idx_cmp[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_a | input | 1 | Phase A (direction level in step mode) |
| ph_b | input | 1 | Phase B (count clock in step mode) |
| idx_in | input | 1 | Index input |
| cfg_dir_inv | input | 1 | Reverse the counting direction |
| cfg_step_mode | input | 1 | 1 = step/direction, 0 = quadrature |
| cfg_x4 | input | 1 | 1 = count both phases, 0 = phase A only |
| cfg_idx_inv | input | 1 | Invert the index sense |
| cfg_idx_gate | input | 4 | Phase states in which the index passes |
| cfg_cont_rst | input | 1 | Continuous clear on index |
| cfg_max_pos | input | W | Wrap limit |
| cfg_pos_cmp | input | NCMP×W | Position compare values |
| cfg_idx_cmp | input | NCMP×W | Index compare values |
| cmd_rst_pos | input | 1 | One-cycle position clear |
| cmd_rst_pos_on_idx | input | 1 | One-cycle arm of clear on next index |
| cmd_rst_idx | input | 1 | One-cycle index count clear |
| position | output | W | Position count |
| dir | output | 1 | Direction of last counted edge |
| idx_count | output | W | Index count |
| ev_count | output | 1 | Edge counted |
| ev_phase_err | output | 1 | Both phases changed |
| ev_dir_chg | output | 1 | Direction changed |
| ev_wrap | output | 1 | Position wrapped |
| ev_index | output | 1 | Index accepted |
| ev_pos_match | output | NCMP | Position compare matches |
| ev_idx_match | output | NCMP | Index compare matches |

## Verification
The assertions assume the following about the inputs:
- Commands are single-cycle pulses.
- `cfg_max_pos` and the compare values are held steady around the edges they are checked on.
- Mode bits change only while the phases are idle, so a mode switch never meets a phase transition.

The stimulus changes the inputs only on falling clock edges. It moves the phases one Gray step at a time except where a phase error is wanted on purpose. It flips configuration only during idle gaps with the phases held. Each index pulse spans a known phase state, so gated and blocked cases are both produced on purpose.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    // Last sampled phase pair, encoded {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_t;

    // Index recalibration controller
    typedef enum logic [1:0] {
        ARM_IDLE      = 2'd0,
        ARM_ONCE      = 2'd1,
        ARM_CONT_WAIT = 2'd2,
        ARM_CONT_PEND = 2'd3
    } arm_t;

    // Per-sample decode result
    typedef struct packed {
        logic cnt;   // an edge is counted
        logic fwd;   // effective direction of that edge
        logic err;   // both phases moved
    } step_t;

endpackage

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ph_a,
    input  logic  ph_b,
    input  logic  step_mode,
    input  logic  x4,
    input  logic  dir_inv,
    output step_t step
);

    phase_t cur_q;
    phase_t now_s;
    logic   a_edge;
    logic   b_edge;
    logic   raw_fwd;
    logic   both;

    assign now_s = phase_t'({ph_a, ph_b});

    // state register: follows the phase pair every sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= PH_00;
        else        cur_q <= now_s;
    end

    // transition classification per current state
    always_comb begin
        a_edge  = 1'b0;
        b_edge  = 1'b0;
        both    = 1'b0;
        raw_fwd = 1'b0;
        unique case (cur_q)
            PH_00: begin
                case (now_s)
                    PH_10:   begin a_edge = 1'b1; raw_fwd = 1'b1; end
                    PH_01:   begin b_edge = 1'b1; raw_fwd = 1'b0; end
                    PH_11:   both = 1'b1;
                    default: ;
                endcase
            end
            PH_10: begin
                case (now_s)
                    PH_11:   begin b_edge = 1'b1; raw_fwd = 1'b1; end
                    PH_00:   begin a_edge = 1'b1; raw_fwd = 1'b0; end
                    PH_01:   both = 1'b1;
                    default: ;
                endcase
            end
            PH_11: begin
                case (now_s)
                    PH_01:   begin a_edge = 1'b1; raw_fwd = 1'b1; end
                    PH_10:   begin b_edge = 1'b1; raw_fwd = 1'b0; end
                    PH_00:   both = 1'b1;
                    default: ;
                endcase
            end
            PH_01: begin
                case (now_s)
                    PH_00:   begin b_edge = 1'b1; raw_fwd = 1'b1; end
                    PH_11:   begin a_edge = 1'b1; raw_fwd = 1'b0; end
                    PH_10:   both = 1'b1;
                    default: ;
                endcase
            end
        endcase
    end

    // output process: mode selection
    always_comb begin
        if (step_mode) begin
            step.cnt = ~cur_q[0] & ph_b;
            step.fwd = ph_a ^ dir_inv;
            step.err = 1'b0;
        end else begin
            step.cnt = a_edge | (b_edge & x4);
            step.fwd = raw_fwd ^ dir_inv;
            step.err = both;
        end
    end

endmodule

// File: rtl/qpc_arm.sv
module qpc_arm
    import qpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_once,
    input  logic cont_en,
    input  logic accept,
    input  logic fwd_cnt,
    output logic clr,
    output arm_t state
);

    arm_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARM_IDLE;
        else        state <= nxt;
    end

    // next-state process
    always_comb begin
        nxt = state;
        unique case (state)
            ARM_IDLE: begin
                if (cmd_once)     nxt = ARM_ONCE;
                else if (cont_en) nxt = ARM_CONT_WAIT;
            end
            ARM_ONCE: begin
                if (accept) nxt = ARM_IDLE;
            end
            ARM_CONT_WAIT: begin
                if (cmd_once)                nxt = ARM_ONCE;
                else if (!cont_en)           nxt = ARM_IDLE;
                else if (accept && !fwd_cnt) nxt = ARM_CONT_PEND;
            end
            ARM_CONT_PEND: begin
                if (cmd_once)      nxt = ARM_ONCE;
                else if (!cont_en) nxt = ARM_IDLE;
                else if (fwd_cnt)  nxt = ARM_CONT_WAIT;
            end
        endcase
    end

    // output process: position clear request
    always_comb begin
        clr = 1'b0;
        unique case (state)
            ARM_IDLE:      clr = 1'b0;
            ARM_ONCE:      clr = accept;
            ARM_CONT_WAIT: clr = !cmd_once && cont_en && accept && fwd_cnt;
            ARM_CONT_PEND: clr = !cmd_once && cont_en && fwd_cnt;
        endcase
    end

endmodule

// File: rtl/qpc_position.sv
module qpc_position
    import qpc_pkg::*;
#(
    parameter int W    = 32,
    parameter int NCMP = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  step_t                   step,
    input  logic                    clr,
    input  logic                    rst_cmd,
    input  logic [W-1:0]            max_pos,
    input  logic [NCMP-1:0][W-1:0]  cmp,
    output logic [W-1:0]            position,
    output logic                    dir,
    output logic                    ev_count,
    output logic                    ev_err,
    output logic                    ev_wrap,
    output logic                    ev_dir_chg,
    output logic [NCMP-1:0]         ev_match
);

    logic [W-1:0]    pos_nxt;
    logic            upd;
    logic            wrap;
    logic [NCMP-1:0] match_nxt;

    always_comb begin
        pos_nxt = position;
        upd     = 1'b0;
        wrap    = 1'b0;
        if (rst_cmd || clr) begin
            pos_nxt = '0;
            upd     = 1'b1;
        end else if (step.cnt) begin
            upd = 1'b1;
            if (step.fwd) begin
                if (position >= max_pos) begin
                    pos_nxt = '0;
                    wrap    = 1'b1;
                end else begin
                    pos_nxt = position + W'(1);
                end
            end else begin
                if (position == '0) begin
                    pos_nxt = max_pos;
                    wrap    = 1'b1;
                end else begin
                    pos_nxt = position - W'(1);
                end
            end
        end
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign match_nxt[i] = upd && (pos_nxt == cmp[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            position   <= '0;
            dir        <= 1'b1;
            ev_count   <= 1'b0;
            ev_err     <= 1'b0;
            ev_wrap    <= 1'b0;
            ev_dir_chg <= 1'b0;
            ev_match   <= '0;
        end else begin
            position   <= pos_nxt;
            ev_count   <= step.cnt;
            ev_err     <= step.err;
            ev_wrap    <= wrap;
            ev_dir_chg <= step.cnt && (step.fwd != dir);
            ev_match   <= match_nxt;
            if (step.cnt) dir <= step.fwd;
        end
    end

    assert_wrap_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wrap |-> (position == '0 || position == $past(max_pos)));

    assert_dirchg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dir_chg |-> (ev_count && dir != $past(dir)));

    assert_err_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err && !$past(rst_cmd) && !$past(clr)) |-> position == $past(position));

    for (genvar i = 0; i < NCMP; i++) begin : g_chk
        assert_pos_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
            ev_match[i] |-> position == $past(cmp[i]));
    end

endmodule

// File: rtl/qpc_index.sv
module qpc_index #(
    parameter int W    = 32,
    parameter int NCMP = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ph_a,
    input  logic                    ph_b,
    input  logic                    idx_in,
    input  logic                    idx_inv,
    input  logic [3:0]              gate,
    input  logic                    dir,
    input  logic                    rst_cmd,
    input  logic [NCMP-1:0][W-1:0]  cmp,
    output logic                    accept,
    output logic [W-1:0]            idx_count,
    output logic                    ev_index,
    output logic [NCMP-1:0]         ev_match
);

    logic            gate_hit;
    logic            ok_now;
    logic            ok_q;
    logic [W-1:0]    cnt_nxt;
    logic            upd;
    logic [NCMP-1:0] match_nxt;

    always_comb begin
        case ({ph_a, ph_b})
            2'b00:   gate_hit = gate[0];
            2'b01:   gate_hit = gate[1];
            2'b11:   gate_hit = gate[2];
            default: gate_hit = gate[3];
        endcase
    end

    assign ok_now = (idx_in ^ idx_inv) & gate_hit;
    assign accept = ok_now & ~ok_q;

    always_comb begin
        cnt_nxt = idx_count;
        upd     = 1'b0;
        if (rst_cmd) begin
            cnt_nxt = '0;
            upd     = 1'b1;
        end else if (accept) begin
            upd     = 1'b1;
            cnt_nxt = dir ? idx_count + W'(1) : idx_count - W'(1);
        end
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign match_nxt[i] = upd && (cnt_nxt == cmp[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q      <= 1'b0;
            idx_count <= '0;
            ev_index  <= 1'b0;
            ev_match  <= '0;
        end else begin
            ok_q      <= ok_now;
            idx_count <= cnt_nxt;
            ev_index  <= accept;
            ev_match  <= match_nxt;
        end
    end

    assert_idx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_index |=> !ev_index);

    assert_idx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> idx_count == '0);

endmodule

// File: rtl/qpc_top.sv
module qpc_top
    import qpc_pkg::*;
#(
    parameter int W    = 32,
    parameter int NCMP = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ph_a,
    input  logic                    ph_b,
    input  logic                    idx_in,
    input  logic                    cfg_dir_inv,
    input  logic                    cfg_step_mode,
    input  logic                    cfg_x4,
    input  logic                    cfg_idx_inv,
    input  logic [3:0]              cfg_idx_gate,
    input  logic                    cfg_cont_rst,
    input  logic [W-1:0]            cfg_max_pos,
    input  logic [NCMP-1:0][W-1:0]  cfg_pos_cmp,
    input  logic [NCMP-1:0][W-1:0]  cfg_idx_cmp,
    input  logic                    cmd_rst_pos,
    input  logic                    cmd_rst_pos_on_idx,
    input  logic                    cmd_rst_idx,
    output logic [W-1:0]            position,
    output logic                    dir,
    output logic [W-1:0]            idx_count,
    output logic                    ev_count,
    output logic                    ev_phase_err,
    output logic                    ev_dir_chg,
    output logic                    ev_wrap,
    output logic                    ev_index,
    output logic [NCMP-1:0]         ev_pos_match,
    output logic [NCMP-1:0]         ev_idx_match
);

    step_t step;
    logic  idx_accept;
    logic  pos_clr;
    arm_t  arm_st;

    qpc_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_a      (ph_a),
        .ph_b      (ph_b),
        .step_mode (cfg_step_mode),
        .x4        (cfg_x4),
        .dir_inv   (cfg_dir_inv),
        .step      (step)
    );

    qpc_index #(.W(W), .NCMP(NCMP)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_a      (ph_a),
        .ph_b      (ph_b),
        .idx_in    (idx_in),
        .idx_inv   (cfg_idx_inv),
        .gate      (cfg_idx_gate),
        .dir       (dir),
        .rst_cmd   (cmd_rst_idx),
        .cmp       (cfg_idx_cmp),
        .accept    (idx_accept),
        .idx_count (idx_count),
        .ev_index  (ev_index),
        .ev_match  (ev_idx_match)
    );

    qpc_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_once (cmd_rst_pos_on_idx),
        .cont_en  (cfg_cont_rst),
        .accept   (idx_accept),
        .fwd_cnt  (step.cnt & step.fwd),
        .clr      (pos_clr),
        .state    (arm_st)
    );

    qpc_position #(.W(W), .NCMP(NCMP)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .clr        (pos_clr),
        .rst_cmd    (cmd_rst_pos),
        .max_pos    (cfg_max_pos),
        .cmp        (cfg_pos_cmp),
        .position   (position),
        .dir        (dir),
        .ev_count   (ev_count),
        .ev_err     (ev_phase_err),
        .ev_wrap    (ev_wrap),
        .ev_dir_chg (ev_dir_chg),
        .ev_match   (ev_pos_match)
    );

    assert_once_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_st == ARM_ONCE && idx_accept) |=> position == '0);

    assert_cont_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_st == ARM_CONT_PEND && cfg_cont_rst && !cmd_rst_pos_on_idx
         && step.cnt && step.fwd) |=> position == '0);

    assert_step_noerr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_step_mode |=> !ev_phase_err);

    assert_pos_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_pos |=> position == '0);

endmodule

// File: tb/qpc_top_test.sv
`timescale 1ns/1ps
module qpc_top_test;

    localparam int W = 32;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph_a = 0, ph_b = 0, idx_in = 0;
    logic cfg_dir_inv = 0, cfg_step_mode = 0, cfg_x4 = 1, cfg_idx_inv = 0;
    logic [3:0] cfg_idx_gate = 4'b1111;
    logic cfg_cont_rst = 0;
    logic [W-1:0] cfg_max_pos = 32'd1000;
    logic [N-1:0][W-1:0] cfg_pos_cmp;
    logic [N-1:0][W-1:0] cfg_idx_cmp;
    logic cmd_rst_pos = 0, cmd_rst_pos_on_idx = 0, cmd_rst_idx = 0;

    logic [W-1:0] position, idx_count;
    logic dir, ev_count, ev_phase_err, ev_dir_chg, ev_wrap, ev_index;
    logic [N-1:0] ev_pos_match, ev_idx_match;

    int checks = 0;
    int errors = 0;
    bit run = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qpc_top #(.W(W), .NCMP(N)) uut (.*);

    // ---------------- reference model ----------------
    logic [W-1:0] m_pos, m_idx;
    bit m_dir, m_cnt, m_err, m_dchg, m_wrap, m_ev_idx;
    bit [N-1:0] m_pm, m_im;
    bit pa, pb, pok;
    int arm; // 0 idle, 1 once, 2 cont wait, 3 cont pending

    function automatic bit gate_of(bit a, bit b);
        if (!a && !b) return cfg_idx_gate[0];
        if (!a &&  b) return cfg_idx_gate[1];
        if ( a &&  b) return cfg_idx_gate[2];
        return cfg_idx_gate[3];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_idx = 0; m_dir = 1;
            {m_cnt, m_err, m_dchg, m_wrap, m_ev_idx} = 5'b0;
            m_pm = 0; m_im = 0; pa = 0; pb = 0; pok = 0; arm = 0;
        end else begin
            bit cnt, fwd, err, ok, acc, clr, pu, iu;
            int nxt_arm;
            cnt = 0; fwd = 0; err = 0; clr = 0;
            if (cfg_step_mode) begin
                cnt = ph_b && !pb;
                fwd = ph_a;
            end else if ((ph_a != pa) && (ph_b != pb)) begin
                err = 1;
            end else if (ph_a != pa) begin
                cnt = 1; fwd = ph_a ^ ph_b;
            end else if (ph_b != pb) begin
                cnt = cfg_x4; fwd = !(ph_a ^ ph_b);
            end
            fwd = fwd ^ cfg_dir_inv;
            ok = (idx_in ^ cfg_idx_inv) && gate_of(ph_a, ph_b);
            acc = ok && !pok;
            nxt_arm = arm;
            case (arm)
                0: if (cmd_rst_pos_on_idx) nxt_arm = 1; else if (cfg_cont_rst) nxt_arm = 2;
                1: if (acc) begin clr = 1; nxt_arm = 0; end
                2: if (cmd_rst_pos_on_idx) nxt_arm = 1;
                   else if (!cfg_cont_rst) nxt_arm = 0;
                   else if (acc && cnt && fwd) clr = 1;
                   else if (acc) nxt_arm = 3;
                default: if (cmd_rst_pos_on_idx) nxt_arm = 1;
                   else if (!cfg_cont_rst) nxt_arm = 0;
                   else if (cnt && fwd) begin clr = 1; nxt_arm = 2; end
            endcase
            m_wrap = 0; pu = 1;
            if (cmd_rst_pos || clr) m_pos = 0;
            else if (cnt && fwd) begin
                if (m_pos >= cfg_max_pos) begin m_pos = 0; m_wrap = 1; end else m_pos++;
            end else if (cnt) begin
                if (m_pos == 0) begin m_pos = cfg_max_pos; m_wrap = 1; end else m_pos--;
            end else pu = 0;
            iu = 1;
            if (cmd_rst_idx) m_idx = 0;
            else if (acc) m_idx = m_dir ? m_idx + 1 : m_idx - 1;
            else iu = 0;
            m_dchg = cnt && (fwd != m_dir);
            if (cnt) m_dir = fwd;
            m_cnt = cnt; m_err = err; m_ev_idx = acc;
            for (int i = 0; i < N; i++) begin
                m_pm[i] = pu && (m_pos == cfg_pos_cmp[i]);
                m_im[i] = iu && (m_idx == cfg_idx_cmp[i]);
            end
            pa = ph_a; pb = ph_b; pok = ok; arm = nxt_arm;
        end
    end

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run) begin
            check("R2 position", position, m_pos);
            check("R2 ev_count", W'(ev_count), W'(m_cnt));
            check("R4 ev_phase_err", W'(ev_phase_err), W'(m_err));
            check("R6 dir", W'(dir), W'(m_dir));
            check("R6 ev_dir_chg", W'(ev_dir_chg), W'(m_dchg));
            check("R7 ev_wrap", W'(ev_wrap), W'(m_wrap));
            check("R8 idx_count", idx_count, m_idx);
            check("R8 ev_index", W'(ev_index), W'(m_ev_idx));
            check("R12 ev_pos_match", W'(ev_pos_match), W'(m_pm));
            check("R12 ev_idx_match", W'(ev_idx_match), W'(m_im));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic move(bit fwd, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fwd == (ph_a == ph_b)) ph_a = ~ph_a; else ph_b = ~ph_b;
        end
    endtask

    task automatic pulse_idx(int len);
        @(negedge clk); idx_in = ~cfg_idx_inv;
        tick(len);
        idx_in = cfg_idx_inv;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            cfg_pos_cmp[i] = 32'(3 + i);
            cfg_idx_cmp[i] = 32'(i + 1);
        end
        tick(3);
        // R1: reset state
        check("R1 position", position, 0);
        check("R1 idx_count", idx_count, 0);
        check("R1 dir", W'(dir), 1);
        check("R1 strobes", W'({ev_count, ev_wrap, ev_index, ev_pos_match}), 0);
        rst_n = 1; run = 1;
        tick(2);
        // R2: 4X forward then reverse
        move(1, 8); tick(1);
        check("R2 fwd8", position, 8);
        move(0, 3); tick(1);
        move(1, 3); tick(1);
        // R3: 2X, only A edges count
        cfg_x4 = 0; tick(1);
        move(1, 4); tick(1);
        check("R3 2x", position, 10);
        move(0, 4); tick(1);
        cfg_x4 = 1; tick(1);
        // R4: both phases change
        @(negedge clk); ph_a = ~ph_a; ph_b = ~ph_b;
        tick(2);
        @(negedge clk); ph_a = ~ph_a; ph_b = ~ph_b;
        tick(2);
        // R6: direction invert
        cfg_dir_inv = 1; tick(1);
        move(1, 5); tick(1);
        cfg_dir_inv = 0; tick(1);
        move(1, 5); tick(1);
        // R7: wrap both ways with a small limit
        cfg_max_pos = 5;
        @(negedge clk); cmd_rst_pos = 1; @(negedge clk); cmd_rst_pos = 0;
        check("R9 rst_pos", position, 0);
        move(1, 8); move(0, 9); tick(1);
        // R8: index gating and invert
        cfg_max_pos = 1000;
        cfg_idx_gate = 4'b0001;             // pass only at (A,B)=00
        while (ph_a || ph_b) move(1, 1);
        pulse_idx(2); tick(1);
        move(1, 1); pulse_idx(2); tick(1);   // at 10: blocked
        move(0, 1); tick(1);
        cfg_idx_inv = 1; idx_in = 1; tick(1);
        pulse_idx(1); tick(1);
        cfg_idx_inv = 0; idx_in = 0;
        cfg_idx_gate = 4'b1111; tick(1);
        move(0, 2); pulse_idx(1); pulse_idx(1); tick(1);
        // R9: index clear
        @(negedge clk); cmd_rst_idx = 1; @(negedge clk); cmd_rst_idx = 0;
        check("R9 rst_idx", idx_count, 0);
        // R5: step mode
        cfg_step_mode = 1; ph_a = 1; ph_b = 0; tick(1);
        for (int i = 0; i < 6; i++) begin @(negedge clk); ph_b = ~ph_b; end
        ph_a = 0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); ph_b = ~ph_b; end
        @(negedge clk); ph_a = 1; ph_b = 0; tick(2);
        check("R5 step pos", position, m_pos);
        cfg_step_mode = 0; ph_a = 0; ph_b = 0; tick(2);
        // R10: one-shot clear on index
        move(1, 7);
        @(negedge clk); cmd_rst_pos_on_idx = 1; @(negedge clk); cmd_rst_pos_on_idx = 0;
        move(1, 2); pulse_idx(1); tick(1);
        check("R10 once", position, m_pos);
        move(1, 3); pulse_idx(1); tick(1);
        check("R10 disarmed", position, m_pos);
        // R11: continuous clear
        cfg_cont_rst = 1; tick(2);
        move(1, 6); pulse_idx(1); move(1, 1); tick(1);
        check("R11 pend", position, m_pos);
        move(1, 5);
        @(negedge clk); idx_in = 1;
        if (ph_a == ph_b) ph_a = ~ph_a; else ph_b = ~ph_b;
        @(negedge clk); idx_in = 0; tick(1);
        check("R11 same", position, m_pos);
        cfg_cont_rst = 0; tick(2);
        // R12: compare hits on the way
        move(1, 6); move(0, 6); tick(2);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule